// File: doc/BRIEF.md
# Per-Processor Soft Interrupt Bank

This block keeps one 32-bit pending register for each of sixteen processors. Software can raise and drop interrupts in the upper half of each register. A system router pulses level events into the lower half of the register of whichever processor it currently targets. For every processor the block drives fifteen interrupt-level lines. Each line is the OR of the level vector the router delivers for that processor and the software-raised bits, moved down by sixteen positions.

A processor reaches its own register window through a 4 KB page stride. Address bits 15:12 select the processor and bits 3:2 select one of four words. Word 0 reads the pending register. Word 1 writes ones to clear software bits, and word 2 writes ones to set them. Word 3 reads zero and ignores writes. Reads are combinational from the address. Writes, router events and the level lines are registered.

Top module: `softirq_bank`

## Requirements
- R1: After reset every pending register reads 0x00000000 and every level line is low.
- R2: With busAddr[15:12] = c and busAddr[3:2] = 0, busRdData returns the pending register of processor c. Changes made by a write or router event at one clock edge are visible from that edge onward.
- R3: When busAddr[3:2] is 1, 2 or 3, busRdData is zero.
- R4: A write to word 1 clears the pending bits of processor c that are set in the written value, limited to bits 31:17. If bit 14 of the value is 1, bit 31 is cleared as well. All other bits of the value have no effect.
- R5: A write to word 2 sets the pending bits of processor c that are set in the written value, limited to bits 31:17. Bits 16:0 of the value are ignored.
- R6: A write to word 0 or word 3 leaves the pending register unchanged.
- R7: A router strobe with hwRaise = 1 and level L in 1..15 sets bit L of the pending register of processor hwTarget. With hwRaise = 0 it clears that bit. Level 0 changes nothing.
- R8: Level line lvlOut[i*15 + (k-1)] for processor i and level k in 1..15 equals routedVec[i*16 + k] OR pending bit k+16 of processor i. It is registered, so it follows the pending state one clock after that state changes.
- R9: Bits 0 and 16 of every pending register always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | Register address: processor in 15:12, word in 3:2 |
| busWrEn | input | 1 | Write strobe for one cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for the addressed word |
| hwStrobe | input | 1 | Router level event valid |
| hwRaise | input | 1 | 1 raises, 0 lowers the level |
| hwLevel | input | 4 | Interrupt level of the event |
| hwTarget | input | 4 | Processor the router currently targets |
| routedVec | input | 256 | Routed level vector, 16 bits per processor |
| lvlOut | output | 240 | Registered level lines, 15 per processor |

## Verification
The assertions check on every cycle that the reserved bits stay zero and that non-pending words read zero. They also check the one-cycle effects of single commands: the clear quirk on bit 31, a set landing in the soft bits, a router raise reaching its target, and writes to word 0 or 3 leaving the soft half alone. Only the bench scenarios show the full register contents after long mixes of commands, the independence of the sixteen processors, and the exact level line pattern for random routed vectors.

// File: rtl/softirq_pkg.sv
package softirq_pkg;
  localparam int unsigned CPU_CNT    = 16;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned LVL_CNT    = 16;
  localparam int unsigned ADDR_W     = 16;
  localparam int unsigned CPU_W      = $clog2(CPU_CNT);
  localparam int unsigned LVL_W      = $clog2(LVL_CNT);
  localparam int unsigned CPU_LSB    = 12;
  localparam int unsigned WORD_LSB   = 2;
  localparam int unsigned SOFT_SHIFT = 16;
  localparam int unsigned QUIRK_BIT  = 14;

  // software-owned field: bits above SOFT_SHIFT
  localparam logic [DATA_W-1:0] SOFT_MASK =
    {{(DATA_W-SOFT_SHIFT-1){1'b1}}, {(SOFT_SHIFT+1){1'b0}}};

  typedef enum logic [1:0] {
    WORD_PEND = 2'd0,
    WORD_CLR  = 2'd1,
    WORD_SET  = 2'd2,
    WORD_NONE = 2'd3
  } word_e;

  typedef struct packed {
    logic              softSet;
    logic              softClr;
    logic [CPU_W-1:0]  busCpu;
    logic [DATA_W-1:0] softBits;
    logic              hwSet;
    logic              hwClr;
    logic [CPU_W-1:0]  hwCpu;
    logic [DATA_W-1:0] hwBits;
  } strobe_t;
endpackage

// File: rtl/softirq_ctrl.sv
module softirq_ctrl
  import softirq_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              hwStrobe,
  input  logic              hwRaise,
  input  logic [LVL_W-1:0]  hwLevel,
  input  logic [CPU_W-1:0]  hwTarget,
  output strobe_t           strb,
  output logic [CPU_W-1:0]  rdCpu,
  output logic              rdHit
);
  word_e            wordSel;
  logic [DATA_W-1:0] clrVal;
  logic [DATA_W-1:0] levelBit;
  logic             unusedAddrBits;

  assign wordSel = word_e'(busAddr[WORD_LSB +: 2]);
  assign rdCpu   = busAddr[CPU_LSB +: CPU_W];
  assign rdHit   = (wordSel == WORD_PEND);
  assign unusedAddrBits = ^{busAddr[ADDR_W-1 -: (ADDR_W-CPU_LSB-CPU_W+1)],
                            busAddr[CPU_LSB-1:WORD_LSB+2], busAddr[WORD_LSB-1:0]};

  // clear command: the quirk bit also hits the top bit
  always_comb begin
    clrVal = busWrData;
    if (busWrData[QUIRK_BIT]) clrVal[DATA_W-1] = 1'b1;
  end

  always_comb begin
    levelBit = '0;
    if (hwLevel != '0) levelBit[hwLevel] = 1'b1;
  end

  always_comb begin
    strb          = '0;
    strb.busCpu   = rdCpu;
    strb.softSet  = busWrEn && (wordSel == WORD_SET);
    strb.softClr  = busWrEn && (wordSel == WORD_CLR);
    strb.softBits = (strb.softClr ? clrVal : busWrData) & SOFT_MASK;
    strb.hwCpu    = hwTarget;
    strb.hwSet    = hwStrobe && hwRaise;
    strb.hwClr    = hwStrobe && !hwRaise;
    strb.hwBits   = levelBit;
  end
endmodule

// File: rtl/softirq_datapath.sv
module softirq_datapath
  import softirq_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strb,
  input  logic [CPU_W-1:0]              rdCpu,
  input  logic                          rdHit,
  input  logic [CPU_CNT*LVL_CNT-1:0]    routedVec,
  output logic [DATA_W-1:0]             rdData,
  output logic [CPU_CNT*DATA_W-1:0]     pendFlat,
  output logic [CPU_CNT*(LVL_CNT-1)-1:0] lvlOut
);
  logic [DATA_W-1:0] pendArr [CPU_CNT];

  for (genvar g = 0; g < CPU_CNT; g++) begin : g_cpu
    logic [DATA_W-1:0]  pendQ;
    logic [DATA_W-1:0]  pendD;
    logic [LVL_CNT-1:0] combined;
    logic [LVL_CNT-2:0] lineQ;
    logic               unusedLvl0;

    always_comb begin
      pendD = pendQ;
      if (strb.softClr && strb.busCpu == CPU_W'(g)) pendD = pendD & ~strb.softBits;
      if (strb.softSet && strb.busCpu == CPU_W'(g)) pendD = pendD | strb.softBits;
      if (strb.hwSet && strb.hwCpu == CPU_W'(g))    pendD = pendD | strb.hwBits;
      if (strb.hwClr && strb.hwCpu == CPU_W'(g))    pendD = pendD & ~strb.hwBits;
    end

    always_ff @(posedge clk) begin
      if (!rstN) pendQ <= '0;
      else       pendQ <= pendD;
    end

    assign combined   = routedVec[g*LVL_CNT +: LVL_CNT] | pendQ[DATA_W-1 -: LVL_CNT];
    assign unusedLvl0 = combined[0];

    always_ff @(posedge clk) begin
      if (!rstN) lineQ <= '0;
      else       lineQ <= combined[LVL_CNT-1:1];
    end

    assign pendArr[g]                          = pendQ;
    assign pendFlat[g*DATA_W +: DATA_W]        = pendQ;
    assign lvlOut[g*(LVL_CNT-1) +: LVL_CNT-1]  = lineQ;
  end

  assign rdData = rdHit ? pendArr[rdCpu] : '0;
endmodule

// File: rtl/softirq_bank.sv
module softirq_bank
  import softirq_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic                           busWrEn,
  input  logic [DATA_W-1:0]              busWrData,
  output logic [DATA_W-1:0]              busRdData,
  input  logic                           hwStrobe,
  input  logic                           hwRaise,
  input  logic [LVL_W-1:0]               hwLevel,
  input  logic [CPU_W-1:0]               hwTarget,
  input  logic [CPU_CNT*LVL_CNT-1:0]     routedVec,
  output logic [CPU_CNT*(LVL_CNT-1)-1:0] lvlOut
);
  strobe_t                  strb;
  logic [CPU_W-1:0]         rdCpu;
  logic                     rdHit;
  logic [CPU_CNT*DATA_W-1:0] pendFlat;

  softirq_ctrl u_ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .hwStrobe(hwStrobe), .hwRaise(hwRaise), .hwLevel(hwLevel), .hwTarget(hwTarget),
    .strb(strb), .rdCpu(rdCpu), .rdHit(rdHit)
  );

  softirq_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdCpu(rdCpu), .rdHit(rdHit),
    .routedVec(routedVec), .rdData(busRdData), .pendFlat(pendFlat), .lvlOut(lvlOut)
  );
endmodule

// File: rtl/softirq_bank_chk.sv
module softirq_bank_chk
  import softirq_pkg::*;
(
  input logic                      clk,
  input logic                      rstN,
  input logic [ADDR_W-1:0]         busAddr,
  input logic                      busWrEn,
  input logic [DATA_W-1:0]         busWrData,
  input logic [DATA_W-1:0]         busRdData,
  input logic                      hwStrobe,
  input logic                      hwRaise,
  input logic [LVL_W-1:0]          hwLevel,
  input logic [CPU_W-1:0]          hwTarget,
  input logic [CPU_CNT*DATA_W-1:0] pendFlat
);
  localparam int unsigned BIT_W = $clog2(DATA_W);

  logic [CPU_W-1:0] aCpu;
  logic [1:0]       aWord;
  assign aCpu  = busAddr[CPU_LSB +: CPU_W];
  assign aWord = busAddr[WORD_LSB +: 2];

  for (genvar g = 0; g < CPU_CNT; g++) begin : g_res
    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
      pendFlat[g*DATA_W] == 1'b0 && pendFlat[g*DATA_W + SOFT_SHIFT] == 1'b0);
  end

  a_r3_other_words_zero: assert property (@(posedge clk) disable iff (!rstN)
    aWord != 2'd0 |-> busRdData == '0);

  a_r4_clear_quirk: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && aWord == 2'd1 && busWrData[QUIRK_BIT]
    |=> pendFlat[{$past(aCpu), BIT_W'(DATA_W-1)}] == 1'b0);

  a_r5_set_lands: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && aWord == 2'd2
    |=> (pendFlat[{$past(aCpu), BIT_W'(0)} +: DATA_W] & $past(busWrData) & SOFT_MASK)
        == ($past(busWrData) & SOFT_MASK));

  a_r6_dead_words: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && (aWord == 2'd0 || aWord == 2'd3)
    |=> pendFlat[{$past(aCpu), BIT_W'(SOFT_SHIFT)} +: SOFT_SHIFT]
        == $past(pendFlat[{aCpu, BIT_W'(SOFT_SHIFT)} +: SOFT_SHIFT]));

  a_r7_hw_raise: assert property (@(posedge clk) disable iff (!rstN)
    hwStrobe && hwRaise && hwLevel != '0
    |=> pendFlat[{$past(hwTarget), BIT_W'($past(hwLevel))}] == 1'b1);
endmodule

bind softirq_bank softirq_bank_chk u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .busRdData(busRdData), .hwStrobe(hwStrobe),
  .hwRaise(hwRaise), .hwLevel(hwLevel), .hwTarget(hwTarget), .pendFlat(pendFlat)
);

// File: tb/softirq_bank_bench.sv
`timescale 1ns/1ps
module softirq_bank_bench;
  localparam logic [31:0] SMASK = 32'hFFFE0000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [15:0]  busAddr = '0;
  logic         busWrEn = 1'b0;
  logic [31:0]  busWrData = '0;
  logic [31:0]  busRdData;
  logic         hwStrobe = 1'b0;
  logic         hwRaise = 1'b0;
  logic [3:0]   hwLevel = '0;
  logic [3:0]   hwTarget = '0;
  logic [255:0] routedVec = '0;
  logic [239:0] lvlOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] expPend [16];

  always #2.5 clk = ~clk;

  softirq_bank u_softirq_bank (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .hwStrobe(hwStrobe),
    .hwRaise(hwRaise), .hwLevel(hwLevel), .hwTarget(hwTarget),
    .routedVec(routedVec), .lvlOut(lvlOut)
  );

  function automatic logic [239:0] expLines();
    logic [239:0] v = '0;
    for (int i = 0; i < 16; i++)
      for (int k = 1; k < 16; k++)
        v[i*15 + k - 1] = routedVec[i*16 + k] | expPend[i][k+16];
    return v;
  endfunction

  task automatic chk(string req, logic [239:0] act, logic [239:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // read word 0 (or another word) of a processor at the negedge
  task automatic readWord(int cpu, int word, string req, logic [31:0] exp);
    busWrEn = 1'b0;
    busAddr = 16'((cpu << 12) | (word << 2));
    #1;
    chk(req, 240'(busRdData), 240'(exp));
  endtask

  // one command cycle, then an idle cycle so the level lines settle
  task automatic step(bit doWr, int cpu, int word, logic [31:0] data,
                      bit doHw, bit raise, int lvl, int tgt);
    logic [31:0] v;
    busAddr   = 16'((cpu << 12) | (word << 2));
    busWrEn   = doWr;
    busWrData = data;
    hwStrobe  = doHw;
    hwRaise   = raise;
    hwLevel   = 4'(lvl);
    hwTarget  = 4'(tgt);
    @(posedge clk);
    @(negedge clk);
    busWrEn  = 1'b0;
    hwStrobe = 1'b0;
    if (doWr && word == 1) begin
      v = data;
      if (data[14]) v[31] = 1'b1;
      expPend[cpu] &= ~(v & SMASK);
    end
    if (doWr && word == 2) expPend[cpu] |= data & SMASK;
    if (doHw && lvl != 0) begin
      if (raise) expPend[tgt][lvl] = 1'b1;
      else       expPend[tgt][lvl] = 1'b0;
    end
    @(negedge clk);
    chk("R8 level lines", lvlOut, expLines());
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 16; i++) expPend[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 lines after reset", lvlOut, '0);
    for (int i = 0; i < 16; i++) readWord(i, 0, "R1 pending after reset", 32'h0);

    // R5: set with all ones only lands in 31:17
    step(1, 3, 2, 32'hFFFFFFFF, 0, 0, 0, 0);
    readWord(3, 0, "R5 set masked", 32'hFFFE0000);
    // R3: other words read zero
    readWord(3, 1, "R3 word1 reads zero", 32'h0);
    readWord(3, 2, "R3 word2 reads zero", 32'h0);
    readWord(3, 3, "R3 word3 reads zero", 32'h0);
    // R6: dead words
    step(1, 3, 0, 32'h00000000, 0, 0, 0, 0);
    readWord(3, 0, "R6 word0 write ignored", 32'hFFFE0000);
    step(1, 3, 3, 32'h00000000, 0, 0, 0, 0);
    step(1, 3, 3, 32'hFFFFFFFF, 0, 0, 0, 0);
    readWord(3, 0, "R6 word3 write ignored", 32'hFFFE0000);
    // R4: quirk bit clears only bit 31
    step(1, 3, 1, 32'h00004000, 0, 0, 0, 0);
    readWord(3, 0, "R4 quirk clear", 32'h7FFE0000);
    step(1, 3, 1, 32'h0001FFFF & ~32'h00004000, 0, 0, 0, 0);
    readWord(3, 0, "R4 low bits ignored", 32'h7FFE0000);
    step(1, 3, 1, 32'h00060000, 0, 0, 0, 0);
    readWord(3, 0, "R4 clear soft bits", 32'h7FF80000);
    // R7: router events
    step(0, 0, 0, 0, 1, 1, 0, 7);
    readWord(7, 0, "R7 level 0 ignored", 32'h0);
    step(0, 0, 0, 0, 1, 1, 5, 7);
    readWord(7, 0, "R7 raise level 5", 32'h00000020);
    readWord(6, 0, "R2 neighbour untouched", 32'h0);
    step(0, 0, 0, 0, 1, 0, 5, 7);
    readWord(7, 0, "R7 lower level 5", 32'h0);
    // R8: routed level only
    routedVec = '0;
    routedVec[9*16 + 15] = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, 0);

    // random mix
    for (int n = 0; n < 500; n++) begin
      int c;
      int w;
      if ($urandom_range(0, 3) == 0)
        routedVec = {$urandom(), $urandom(), $urandom(), $urandom(),
                     $urandom(), $urandom(), $urandom(), $urandom()};
      c = $urandom_range(0, 15);
      w = $urandom_range(0, 3);
      step($urandom_range(0, 1), c, w, $urandom(),
           $urandom_range(0, 1), $urandom_range(0, 1),
           $urandom_range(0, 15), $urandom_range(0, 15));
      readWord(c, 0, "R2 pending readback", expPend[c]);
      checks++;
      if ((busRdData & 32'h00010001) != 0) begin
        fails++;
        $display("FAIL R9 reserved bits actual=%h expected=0", busRdData & 32'h00010001);
      end
    end
    for (int i = 0; i < 16; i++) readWord(i, 0, "R2 final contents", expPend[i]);

    done = 1'b1;
    finishRun();
  end
endmodule